// File: doc/BRIEF.md
# Per-Core Local Interrupt Router

This block collects the interrupt requests that belong to each core of a small cluster and turns them into one interrupt line per core. Every core has four timer requests, a performance-monitor request and a mailbox request. One fast request from a shared peripheral also enters the block. Timer requests are gated by a per-core enable word. Performance-monitor requests are gated by a routing mask, one bit per core. Mailbox requests pass through without a gate. The shared peripheral request goes only to core 0.

A simple register bus reaches the state. One access happens per cycle, reads are combinational, and a write takes effect at the clock edge. Software reads a core's pending word to find out why that core was interrupted. The bit positions in that word are fixed so that a handler can decode them directly.

Top module: `local_irq_router`

## Requirements
- R1: Synchronous active-high reset clears every timer enable word and the whole routing mask. After reset, every core_irq is low while no mailbox request or shared request is raised.
- R2: The timer enable word of core c is read and written at byte address 0x40+4c. Bits [3:0] enable, in order, the secure physical timer, the non-secure physical timer, the hypervisor timer and the virtual timer. A write stores bits [3:0], and bits [31:4] always read as zero.
- R3: A write to the route-set address 0x00 sets routing bit n for every one in data bit n and leaves the other routing bits unchanged. Reading 0x00 returns the routing mask in bits [NUM_CORES-1:0].
- R4: A write to the route-clear address 0x04 clears routing bit n for every one in data bit n and leaves the other routing bits unchanged. Reading 0x04 also returns the routing mask.
- R5: The read-only pending word of core c is at 0x60+4c, with this layout: bits [3:0] hold the timers in the R2 order, bit 4 holds the mailbox, bit 8 holds the shared peripheral and bit 9 holds the performance monitor. All other bits are zero.
- R6: Timer pending bit t of core c equals timer request 4c+t AND enable bit t of core c.
- R7: Performance-monitor pending bit 9 of core c equals pmu_req[c] AND routing bit c.
- R8: Mailbox pending bit 4 of core c equals mbox_req[c], with no mask.
- R9: Pending bit 8 equals periph_req for core 0 and is zero for every other core.
- R10: core_irq[c] is high exactly when the pending word of core c is non-zero, in the same cycle as the requests.
- R11: Reads of any address not listed in R2 to R5, misaligned addresses included, return zero. Writes to those addresses or to the pending words change no state. bus_rdata is zero whenever no read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_req | input | 4*NUM_CORES | Timer requests, core c at [4c+3:4c] |
| pmu_req | input | NUM_CORES | Performance-monitor request per core |
| mbox_req | input | NUM_CORES | Mailbox request per core |
| periph_req | input | 1 | Shared fast peripheral request |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| core_irq | output | NUM_CORES | Interrupt line per core |

## Verification
The bench drives stimulus aimed at the places where a router like this usually goes wrong:
- Set and clear writes with sparse and zero masks. A design that wrote the mask directly would wipe out routing bits that are already set.
- Timer enable writes with high garbage bits. A register that was too wide would read them back.
- The shared request held high while other cores are read. A design that broadcast it would raise their lines.
- Writes to pending words, misaligned addresses and holes in the address map, each followed by a full read-back. These catch a decoder that aliases one address onto another.

After the directed cases, random traffic runs against the cycle-by-cycle model, covering mixed requests and bus accesses.

// File: rtl/lir_pkg.sv
package lir_pkg;

    localparam int unsigned ADDR_W    = 8;
    localparam int unsigned REG_W     = 32;
    localparam int unsigned TMR_SRCS  = 4;
    localparam int unsigned MAX_CORES = 8;
    localparam int unsigned CORE_W    = 3;

    localparam logic [ADDR_W-1:0] ROUTE_SET_ADDR = 8'h00;
    localparam logic [ADDR_W-1:0] ROUTE_CLR_ADDR = 8'h04;
    localparam logic [ADDR_W-1:0] TEN_BASE       = 8'h40;
    localparam logic [ADDR_W-1:0] PEND_BASE      = 8'h60;

    localparam int unsigned PB_MBOX   = 4;
    localparam int unsigned PB_SHARED = 8;
    localparam int unsigned PB_PMU    = 9;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_ROUTE_SET,
        ACC_ROUTE_CLR,
        ACC_TEN,
        ACC_PEND
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e         kind;
        logic [CORE_W-1:0] core;
    } acc_t;

    typedef struct packed {
        logic [TMR_SRCS-1:0] tmr;
        logic                mbox;
        logic                shared;
        logic                pmu;
    } src_t;

    function automatic acc_t decode_addr(input logic [ADDR_W-1:0] a,
                                         input int unsigned nc);
        acc_t r;
        r.kind = ACC_NONE;
        r.core = '0;
        if (a == ROUTE_SET_ADDR) r.kind = ACC_ROUTE_SET;
        if (a == ROUTE_CLR_ADDR) r.kind = ACC_ROUTE_CLR;
        for (int unsigned c = 0; c < MAX_CORES; c++) begin
            if (c < nc) begin
                if (a == TEN_BASE + ADDR_W'(4 * c)) begin
                    r.kind = ACC_TEN;
                    r.core = CORE_W'(c);
                end
                if (a == PEND_BASE + ADDR_W'(4 * c)) begin
                    r.kind = ACC_PEND;
                    r.core = CORE_W'(c);
                end
            end
        end
        return r;
    endfunction

    function automatic logic [REG_W-1:0] pack_pending(input src_t s);
        logic [REG_W-1:0] w;
        w = '0;
        w[TMR_SRCS-1:0] = s.tmr;
        w[PB_MBOX]      = s.mbox;
        w[PB_SHARED]    = s.shared;
        w[PB_PMU]       = s.pmu;
        return w;
    endfunction

endpackage

// File: rtl/lir_regs.sv
module lir_regs
    import lir_pkg::*;
#(
    parameter int unsigned NUM_CORES = 4
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr,
    input  acc_t                              acc,
    input  logic [REG_W-1:0]                  wdata,
    output logic [NUM_CORES-1:0][TMR_SRCS-1:0] tmr_en,
    output logic [NUM_CORES-1:0]              pmu_route
);

    logic [NUM_CORES-1:0] mask_bits;
    logic                 unused_wdata;

    assign mask_bits    = wdata[NUM_CORES-1:0];
    assign unused_wdata = ^wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            pmu_route <= '0;
        end else if (wr && acc.kind == ACC_ROUTE_SET) begin
            pmu_route <= pmu_route | mask_bits;
        end else if (wr && acc.kind == ACC_ROUTE_CLR) begin
            pmu_route <= pmu_route & ~mask_bits;
        end
    end

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_ten
        always_ff @(posedge clk) begin
            if (rst) begin
                tmr_en[c] <= '0;
            end else if (wr && acc.kind == ACC_TEN && acc.core == CORE_W'(c)) begin
                tmr_en[c] <= wdata[TMR_SRCS-1:0];
            end
        end

        p_ten_hold_r2: assert property (@(posedge clk) disable iff (rst)
            !(wr && acc.kind == ACC_TEN && acc.core == CORE_W'(c)) |=> $stable(tmr_en[c]))
            else $error("timer enable of core %0d changed without a write", c);
    end

    p_set_only_ones_r3: assert property (@(posedge clk) disable iff (rst)
        (wr && acc.kind == ACC_ROUTE_SET) |=>
            (((pmu_route ^ $past(pmu_route)) & ~$past(mask_bits)) == '0) &&
            ((pmu_route & $past(mask_bits)) == $past(mask_bits)))
        else $error("route set disturbed unselected bits");

    p_clr_only_ones_r4: assert property (@(posedge clk) disable iff (rst)
        (wr && acc.kind == ACC_ROUTE_CLR) |=>
            (((pmu_route ^ $past(pmu_route)) & ~$past(mask_bits)) == '0) &&
            ((pmu_route & $past(mask_bits)) == '0))
        else $error("route clear disturbed unselected bits");

    p_route_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !(wr && (acc.kind == ACC_ROUTE_SET || acc.kind == ACC_ROUTE_CLR)) |=> $stable(pmu_route))
        else $error("routing mask changed without a set or clear write");

endmodule

// File: rtl/lir_core_pend.sv
module lir_core_pend
    import lir_pkg::*;
(
    input  logic [TMR_SRCS-1:0] tmr_req,
    input  logic [TMR_SRCS-1:0] tmr_en,
    input  logic                mbox_req,
    input  logic                shared_req,
    input  logic                pmu_req,
    input  logic                pmu_route,
    output logic [REG_W-1:0]    pend_word,
    output logic                irq
);

    src_t src;

    always_comb begin
        src.tmr    = tmr_req & tmr_en;
        src.mbox   = mbox_req;
        src.shared = shared_req;
        src.pmu    = pmu_req & pmu_route;
    end

    assign pend_word = pack_pending(src);
    assign irq       = |pend_word;

endmodule

// File: rtl/local_irq_router.sv
module local_irq_router
    import lir_pkg::*;
#(
    parameter int unsigned NUM_CORES = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [TMR_SRCS*NUM_CORES-1:0] tmr_req,
    input  logic [NUM_CORES-1:0]          pmu_req,
    input  logic [NUM_CORES-1:0]          mbox_req,
    input  logic                          periph_req,
    input  logic                          bus_sel,
    input  logic                          bus_we,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [REG_W-1:0]              bus_wdata,
    output logic [REG_W-1:0]              bus_rdata,
    output logic [NUM_CORES-1:0]          core_irq
);

    acc_t                               acc;
    logic                               wr;
    logic                               rd;
    logic [NUM_CORES-1:0][TMR_SRCS-1:0] tmr_en;
    logic [NUM_CORES-1:0]               pmu_route;
    logic [NUM_CORES-1:0][REG_W-1:0]    pend_words;

    assign acc = decode_addr(bus_addr, NUM_CORES);
    assign wr  = bus_sel && bus_we;
    assign rd  = bus_sel && !bus_we;

    lir_regs #(.NUM_CORES(NUM_CORES)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr        (wr),
        .acc       (acc),
        .wdata     (bus_wdata),
        .tmr_en    (tmr_en),
        .pmu_route (pmu_route)
    );

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        lir_core_pend u_pend (
            .tmr_req    (tmr_req[c*TMR_SRCS +: TMR_SRCS]),
            .tmr_en     (tmr_en[c]),
            .mbox_req   (mbox_req[c]),
            .shared_req ((c == 0) ? periph_req : 1'b0),
            .pmu_req    (pmu_req[c]),
            .pmu_route  (pmu_route[c]),
            .pend_word  (pend_words[c]),
            .irq        (core_irq[c])
        );

        p_irq_has_source_r10: assert property (@(posedge clk) disable iff (rst)
            core_irq[c] |-> ((|(tmr_req[c*TMR_SRCS +: TMR_SRCS] & tmr_en[c])) ||
                             mbox_req[c] || (pmu_req[c] && pmu_route[c]) ||
                             (c == 0 && periph_req)))
            else $error("core %0d interrupt without an enabled source", c);

        p_source_raises_irq_r10: assert property (@(posedge clk) disable iff (rst)
            (mbox_req[c] || (pmu_req[c] && pmu_route[c]) ||
             (|(tmr_req[c*TMR_SRCS +: TMR_SRCS] & tmr_en[c]))) |-> core_irq[c])
            else $error("core %0d enabled source without interrupt", c);

        p_pend_read_quiet_r5: assert property (@(posedge clk) disable iff (rst)
            (rd && acc.kind == ACC_PEND && acc.core == CORE_W'(c) && !core_irq[c])
                |-> bus_rdata == '0)
            else $error("pending read of idle core %0d returned data", c);
    end

    always_comb begin
        bus_rdata = '0;
        if (rd) begin
            unique case (acc.kind)
                ACC_ROUTE_SET, ACC_ROUTE_CLR: bus_rdata[NUM_CORES-1:0] = pmu_route;
                ACC_TEN: begin
                    for (int c = 0; c < NUM_CORES; c++)
                        if (acc.core == CORE_W'(c)) bus_rdata[TMR_SRCS-1:0] = tmr_en[c];
                end
                ACC_PEND: begin
                    for (int c = 0; c < NUM_CORES; c++)
                        if (acc.core == CORE_W'(c)) bus_rdata = pend_words[c];
                end
                default: bus_rdata = '0;
            endcase
        end
    end

    p_idle_bus_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !rd |-> bus_rdata == '0)
        else $error("read data driven without a read");

endmodule

// File: tb/local_irq_router_test.sv
module local_irq_router_test;

    localparam int NC = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] treq;
    logic [3:0]  pmu;
    logic [3:0]  mbox;
    logic        periph;
    logic        sel, we;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic [3:0]  irq;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    logic [3:0] m_ten [NC];
    logic [3:0] m_route;

    always #5 clk = ~clk;

    local_irq_router #(.NUM_CORES(NC)) uut (
        .clk(clk), .rst(rst), .tmr_req(treq), .pmu_req(pmu), .mbox_req(mbox),
        .periph_req(periph), .bus_sel(sel), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .core_irq(irq)
    );

    function automatic logic [31:0] exp_pend(int c);
        logic [31:0] p = 32'h0;
        for (int t = 0; t < 4; t++)
            if (treq[c*4+t] && m_ten[c][t]) p[t] = 1'b1;
        if (mbox[c]) p[4] = 1'b1;
        if (c == 0 && periph) p[8] = 1'b1;
        if (pmu[c] && m_route[c]) p[9] = 1'b1;
        return p;
    endfunction

    function automatic logic [31:0] exp_read();
        logic [31:0] r = 32'h0;
        if (!(sel && !we)) return 32'h0;
        if (addr == 8'h00 || addr == 8'h04) r = {28'h0, m_route};
        for (int c = 0; c < NC; c++) begin
            if (addr == 8'h40 + 8'(4*c)) r = {28'h0, m_ten[c]};
            if (addr == 8'h60 + 8'(4*c)) r = exp_pend(c);
        end
        return r;
    endfunction

    task automatic step(input string tag, input logic s, input logic w,
                        input logic [7:0] a, input logic [31:0] d);
        logic [3:0] ei;
        logic [31:0] er;
        sel = s; we = w; addr = a; wdata = d;
        #4;
        for (int c = 0; c < NC; c++) ei[c] = (exp_pend(c) != 0);
        er = exp_read();
        vectors++;
        if (irq !== ei) begin
            fails++;
            $display("FAIL %s: core_irq actual %b expected %b", tag, irq, ei);
        end
        vectors++;
        if (rdata !== er) begin
            fails++;
            $display("FAIL %s: bus_rdata at 0x%02h actual 0x%08h expected 0x%08h",
                     tag, a, rdata, er);
        end
        @(posedge clk);
        if (rst) begin
            m_route = 4'h0;
            for (int c = 0; c < NC; c++) m_ten[c] = 4'h0;
        end else if (s && w) begin
            if (a == 8'h00) m_route = m_route | d[3:0];
            if (a == 8'h04) m_route = m_route & ~d[3:0];
            for (int c = 0; c < NC; c++)
                if (a == 8'h40 + 8'(4*c)) m_ten[c] = d[3:0];
        end
        #1;
    endtask

    task automatic read_all(input string tag);
        step(tag, 1, 0, 8'h00, 0);
        step(tag, 1, 0, 8'h04, 0);
        for (int c = 0; c < NC; c++) step(tag, 1, 0, 8'h40 + 8'(4*c), 0);
        for (int c = 0; c < NC; c++) step(tag, 1, 0, 8'h60 + 8'(4*c), 0);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            summary();
            $finish;
        end
    end

    initial begin
        m_route = 4'h0;
        for (int c = 0; c < NC; c++) m_ten[c] = 4'h0;
        rst = 1; treq = 0; pmu = 0; mbox = 0; periph = 0;
        sel = 0; we = 0; addr = 0; wdata = 0;
        @(posedge clk); #1;
        step("R1", 0, 0, 8'h00, 0);
        rst = 0;
        // R1: reset state visible through every register
        read_all("R1");
        treq = 16'hFFFF; pmu = 4'hF;
        read_all("R1");
        treq = 0; pmu = 0;

        // R2: enable words, upper bits dropped
        for (int c = 0; c < NC; c++) step("R2", 1, 1, 8'h40 + 8'(4*c), 32'hABCD_EF00 | (c + 9));
        read_all("R2");
        step("R2", 1, 1, 8'h44, 32'hFFFF_FFF0);
        read_all("R2");

        // R3: route set keeps existing ones; zero mask is a no-op
        step("R3", 1, 1, 8'h00, 32'h5);
        step("R3", 1, 0, 8'h00, 0);
        step("R3", 1, 1, 8'h00, 32'hFFFF_FFF2);
        step("R3", 1, 0, 8'h04, 0);
        step("R3", 1, 1, 8'h00, 32'h0);
        step("R3", 1, 0, 8'h00, 0);

        // R4: route clear touches only ones
        step("R4", 1, 1, 8'h04, 32'h4);
        step("R4", 1, 0, 8'h00, 0);
        step("R4", 1, 1, 8'h04, 32'h0);
        step("R4", 1, 0, 8'h04, 0);
        step("R4", 1, 1, 8'h04, 32'hFFFF_FFF1);
        step("R4", 1, 0, 8'h00, 0);

        // R6: timer gating, one source at a time
        for (int c = 0; c < NC; c++) step("R6", 1, 1, 8'h40 + 8'(4*c), 32'h5 << (c % 2));
        for (int t = 0; t < 16; t++) begin
            treq = 16'h1 << t;
            step("R6", 1, 0, 8'h60 + 8'(4*(t/4)), 0);
        end
        treq = 16'hFFFF;
        read_all("R6");
        treq = 0;

        // R7: performance monitor routing
        step("R7", 1, 1, 8'h00, 32'h9);
        pmu = 4'hF;
        read_all("R7");
        pmu = 4'h6;
        read_all("R7");
        step("R7", 1, 1, 8'h04, 32'hF);
        pmu = 4'hF;
        read_all("R7");
        pmu = 0;

        // R8: mailbox is never masked
        for (int c = 0; c < NC; c++) begin
            mbox = 4'h1 << c;
            step("R8", 1, 0, 8'h60 + 8'(4*c), 0);
            step("R8", 0, 0, 8'h00, 0);
        end
        mbox = 0;

        // R9: shared request reaches core 0 only
        periph = 1;
        read_all("R9");
        step("R9", 0, 0, 8'h00, 0);
        periph = 0;

        // R5: full layout with every source raised
        for (int c = 0; c < NC; c++) step("R5", 1, 1, 8'h40 + 8'(4*c), 32'hF);
        step("R5", 1, 1, 8'h00, 32'hF);
        treq = 16'hFFFF; pmu = 4'hF; mbox = 4'hF; periph = 1;
        read_all("R5");
        treq = 0; pmu = 0; mbox = 0; periph = 0;

        // R11: reserved and read-only addresses
        step("R11", 1, 1, 8'h60, 32'hFFFF_FFFF);
        step("R11", 1, 1, 8'h6C, 32'h0);
        step("R11", 1, 1, 8'h41, 32'h0);
        step("R11", 1, 1, 8'h01, 32'hF);
        step("R11", 1, 1, 8'h05, 32'hF);
        step("R11", 1, 1, 8'h5C, 32'h0);
        step("R11", 1, 1, 8'h70, 32'h0);
        step("R11", 1, 1, 8'hFF, 32'h0);
        read_all("R11");
        step("R11", 1, 0, 8'h41, 0);
        step("R11", 1, 0, 8'h08, 0);
        step("R11", 1, 0, 8'h50, 0);
        step("R11", 1, 0, 8'h70, 0);
        step("R11", 1, 0, 8'hFC, 0);

        // R10: random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] a;
            treq = 16'($urandom); pmu = 4'($urandom); mbox = 4'($urandom & $urandom);
            periph = 1'($urandom);
            case ($urandom % 4)
                0: a = 8'h00 + 8'(4 * ($urandom % 2));
                1: a = 8'h40 + 8'(4 * ($urandom % 4));
                2: a = 8'h60 + 8'(4 * ($urandom % 4));
                default: a = 8'($urandom);
            endcase
            step("R10", 1'($urandom), 1'($urandom), a, $urandom);
        end

        done = 1;
        summary();
        $finish;
    end

endmodule